// File: doc/BRIEF.md
# Banked TLB Register Access Port

This block is the register window through which software reads and writes a small translation lookaside buffer array. A bank-select register picks one of four banks of sixteen 32-bit support registers. Two of those banks, bank 1 and bank 2, are MMU banks. Each of them owns one bank of the entry array, organised as four sets of sixteen entries. In an MMU bank a selector register picks the set and the entry that accesses act on.

An entry is built in three steps. The upper word is written to the high register, and that write also lands in a cause register. The selector is set to the target entry. The lower word is then written to the low register. That last write commits the entry: the written value becomes its lower word, and the current cause register becomes its upper word. If the entry being replaced was valid, the block raises a flush request for the old page.

A read of any support register while an MMU bank is active first refreshes the high and low registers of that bank from the selected entry. The read also trims the bank-select register down to its two bank bits.

All pins are plain, one-cycle control and data. The flush request is a one-cycle valid pulse with no back-pressure, so the receiver must accept it in the cycle it appears. Only one register operation is performed per cycle; if a write and a read are requested together, the write wins.

Top module: `tlb_window`

## Requirements
- R1: After reset the bank-select register reads 0, every support register and every array entry is zero, and neither `rd_valid_o` nor `flush_valid_o` is high.
- R2: The active bank is `bsel_q_o[1:0]`. Each of the four banks keeps its own 16 support registers. A write to register n stores the data there, and a read request returns it on `rd_data_o` with `rd_valid_o` high in the next cycle.
- R3: In an MMU bank, selector register 13 picks the set with bits 5:4 and the entry with bits 3:0. Entries in different sets of the same bank are distinct.
- R4: In an MMU bank, a write to high register 6 also writes the same value into cause register 12 of that bank.
- R5: In an MMU bank, a write to low register 5 commits the selected entry. Its lower word becomes the written data and its upper word becomes the cause register value. Bank 1 maps to array bank 0 and bank 2 maps to array bank 1.
- R6: When a commit replaces an entry whose old lower word has bit 3 set, `flush_valid_o` is high for exactly the next cycle. `flush_addr_o` then carries old upper-word bits 31:13 in place, with bits 12:0 zero. When the old entry was not valid, no flush request is raised.
- R7: A read in an MMU bank first reloads that bank's high and low registers from the selected entry. A read of register 6 or 5 therefore returns the entry's upper or lower word, not the last value written to that register.
- R8: A read (not dropped, and with no bank-select write in the same cycle) clears bank-select bits 31:2. Before such a read, the full written value is held and shown on `bsel_q_o`.
- R9: In banks 0 and 3, writes to registers 5 and 6 are plain stores. They touch no cause register, commit nothing, raise no flush request, and reads reload nothing.
- R10: A write and a read requested in the same cycle perform the write only. No read response is produced for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bsel_we_i | input | 1 | Write the bank-select register |
| bsel_wdata_i | input | 32 | Bank-select write data |
| bsel_q_o | output | 32 | Current bank-select register value |
| wr_en_i | input | 1 | Support register write request |
| wr_idx_i | input | 4 | Support register index to write |
| wr_data_i | input | 32 | Support register write data |
| rd_en_i | input | 1 | Support register read request |
| rd_idx_i | input | 4 | Support register index to read |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | 32 | Read data |
| flush_valid_o | output | 1 | One-cycle page flush request |
| flush_addr_o | output | 32 | Page address of the flush request |

## Verification
The bench builds the block with its default parameters: two set bits above four index bits in the selector, low and high registers at 5 and 6, cause at 12 and selector at 13. With these values a selector of 0x25 and one of 0x05 reach the same entry index in different sets, which checks that set bit 5 is decoded. Both MMU banks are used with the same selector value, which shows that each maps to its own array bank. The same entry is committed three times in a row, giving an empty-old, a valid-old and an invalid-old replacement, so both sides of the flush condition are reached. An upper word with bits 12:0 set checks that the flush address is masked.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  localparam int WORD_W    = 32;
  localparam int VPN_LSB   = 13;
  localparam int VALID_BIT = 3;
  localparam int BANK_W    = 2;
  localparam int BANK_CNT  = 1 << BANK_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t hi;
    word_t lo;
  } tlbw_entry_t;

  function automatic word_t page_of(input word_t hi);
    word_t p;
    p = hi;
    p[VPN_LSB-1:0] = '0;
    return p;
  endfunction
endpackage

// File: rtl/tlbw_array.sv
module tlbw_array
  import tlbw_pkg::*;
#(
  parameter int AW = 7,
  localparam int DEPTH = 1 << AW
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [AW-1:0] addr,
  input  tlbw_entry_t wentry,
  output tlbw_entry_t rentry
);
  tlbw_entry_t mem [DEPTH];

  assign rentry = mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wentry;
    end
  end
endmodule

// File: rtl/tlbw_regfile.sv
module tlbw_regfile
  import tlbw_pkg::*;
#(
  parameter int REG_CNT   = 16,
  parameter int LO_REG    = 5,
  parameter int HI_REG    = 6,
  parameter int CAUSE_REG = 12,
  parameter int SEL_REG   = 13,
  localparam int REG_W    = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_idx,
  input  word_t             wr_data,
  input  logic              cause_wr,
  input  logic              mir_ld,
  input  tlbw_entry_t       mir_entry,
  input  logic [REG_W-1:0]  rd_idx,
  output word_t             rd_q,
  output word_t             sel_q,
  output word_t             cause_q
);
  word_t regs [BANK_CNT][REG_CNT];

  assign rd_q    = regs[bank][rd_idx];
  assign sel_q   = regs[bank][SEL_REG];
  assign cause_q = regs[bank][CAUSE_REG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BANK_CNT; b++)
        for (int r = 0; r < REG_CNT; r++)
          regs[b][r] <= '0;
    end else begin
      if (wr_en) regs[bank][wr_idx] <= wr_data;
      if (cause_wr) regs[bank][CAUSE_REG] <= wr_data;
      if (mir_ld) begin
        regs[bank][HI_REG] <= mir_entry.hi;
        regs[bank][LO_REG] <= mir_entry.lo;
      end
    end
  end

  // R4: a side write to the cause register lands in the bank that was active
  a_r4_cause_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_wr && wr_en) |=> (regs[$past(bank)][CAUSE_REG] == $past(wr_data)));
endmodule

// File: rtl/tlbw_flush.sv
module tlbw_flush
  import tlbw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        commit,
  input  tlbw_entry_t old_entry,
  output logic        flush_valid,
  output word_t       flush_addr
);
  logic was_valid;
  assign was_valid = old_entry.lo[VALID_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_valid <= 1'b0;
      flush_addr  <= '0;
    end else begin
      flush_valid <= commit && was_valid;
      if (commit && was_valid) flush_addr <= page_of(old_entry.hi);
    end
  end

  // R6: the reported page address never carries offset bits
  a_r6_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (flush_addr[VPN_LSB-1:0] == '0));
endmodule

// File: rtl/tlb_window.sv
module tlb_window
  import tlbw_pkg::*;
#(
  parameter int SET_W     = 2,
  parameter int IDX_W     = 4,
  parameter int REG_CNT   = 16,
  parameter int LO_REG    = 5,
  parameter int HI_REG    = 6,
  parameter int CAUSE_REG = 12,
  parameter int SEL_REG   = 13,
  localparam int REG_W    = $clog2(REG_CNT),
  localparam int ENT_AW   = 1 + SET_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bsel_we_i,
  input  logic [31:0]      bsel_wdata_i,
  output logic [31:0]      bsel_q_o,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  input  logic             rd_en_i,
  input  logic [REG_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [31:0]      rd_data_o,
  output logic             flush_valid_o,
  output logic [31:0]      flush_addr_o
);
  word_t             bsel_q;
  logic [BANK_W-1:0] bank;
  logic              mmu_bank;
  logic              arr_bank;
  logic              rd_go;
  logic              hi_wr;
  logic              commit;
  word_t             rd_q, sel_q, cause_q;
  logic [ENT_AW-1:0] ent_addr;
  tlbw_entry_t       cur_entry;
  tlbw_entry_t       new_entry;
  word_t             rd_next;

  assign bank     = bsel_q[BANK_W-1:0];
  assign mmu_bank = (bank == BANK_W'(1)) || (bank == BANK_W'(2));
  assign arr_bank = (bank == BANK_W'(2));
  assign rd_go    = rd_en_i && !wr_en_i;
  assign hi_wr    = wr_en_i && mmu_bank && (wr_idx_i == REG_W'(HI_REG));
  assign commit   = wr_en_i && mmu_bank && (wr_idx_i == REG_W'(LO_REG));
  assign ent_addr = {arr_bank, sel_q[IDX_W +: SET_W], sel_q[IDX_W-1:0]};

  assign new_entry.hi = cause_q;
  assign new_entry.lo = wr_data_i;

  always_comb begin
    rd_next = rd_q;
    if (mmu_bank && rd_idx_i == REG_W'(HI_REG)) rd_next = cur_entry.hi;
    if (mmu_bank && rd_idx_i == REG_W'(LO_REG)) rd_next = cur_entry.lo;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsel_q     <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      if (bsel_we_i) bsel_q <= bsel_wdata_i;
      else if (rd_go) bsel_q <= {{(WORD_W-BANK_W){1'b0}}, bank};
      rd_valid_o <= rd_go;
      if (rd_go) rd_data_o <= rd_next;
    end
  end

  assign bsel_q_o = bsel_q;

  tlbw_regfile #(
    .REG_CNT(REG_CNT), .LO_REG(LO_REG), .HI_REG(HI_REG),
    .CAUSE_REG(CAUSE_REG), .SEL_REG(SEL_REG)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bank(bank),
    .wr_en(wr_en_i), .wr_idx(wr_idx_i), .wr_data(wr_data_i),
    .cause_wr(hi_wr),
    .mir_ld(rd_go && mmu_bank), .mir_entry(cur_entry),
    .rd_idx(rd_idx_i), .rd_q(rd_q), .sel_q(sel_q), .cause_q(cause_q)
  );

  tlbw_array #(.AW(ENT_AW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(commit), .addr(ent_addr),
    .wentry(new_entry), .rentry(cur_entry)
  );

  tlbw_flush u_flush (
    .clk(clk), .rst_n(rst_n), .commit(commit), .old_entry(cur_entry),
    .flush_valid(flush_valid_o), .flush_addr(flush_addr_o)
  );

  // R6: a flush request only follows a low-register write
  a_r6_flush_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid_o |-> $past(wr_en_i && wr_idx_i == REG_W'(LO_REG)));

  // R9: writes in the plain banks never raise a flush request
  a_r9_no_flush_plain_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en_i && !mmu_bank) |-> !flush_valid_o);

  // R8: an accepted read trims the bank-select register
  a_r8_bsel_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !wr_en_i && !bsel_we_i) |=> (bsel_q_o[31:BANK_W] == '0));

  // R10: a read response only follows a read that was not overridden
  a_r10_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_en_i && !wr_en_i));
endmodule

// File: tb/tlb_window_tb.sv
module tlb_window_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bsel_we_i = 1'b0;
  logic [31:0] bsel_wdata_i = '0;
  logic [31:0] bsel_q_o;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [3:0]  rd_idx_i = '0;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;
  logic        flush_valid_o;
  logic [31:0] flush_addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_rd[$];
  string       tag_rd[$];
  logic [31:0] exp_fl[$];
  string       tag_fl[$];

  always #5 clk = ~clk;

  tlb_window u_dut (
    .clk(clk), .rst_n(rst_n),
    .bsel_we_i(bsel_we_i), .bsel_wdata_i(bsel_wdata_i), .bsel_q_o(bsel_q_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .flush_valid_o(flush_valid_o), .flush_addr_o(flush_addr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as responses appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rd_valid_o) begin
        if (exp_rd.size() == 0) check("R10 unexpected read response", rd_data_o, 32'hxxxx_xxxx);
        else check(tag_rd.pop_front(), rd_data_o, exp_rd.pop_front());
      end
      if (flush_valid_o) begin
        if (exp_fl.size() == 0) check("R6 unexpected flush", flush_addr_o, 32'hxxxx_xxxx);
        else check(tag_fl.pop_front(), flush_addr_o, exp_fl.pop_front());
      end
    end
  end

  task automatic set_bank(input logic [31:0] v);
    bsel_we_i = 1'b1; bsel_wdata_i = v;
    @(negedge clk);
    bsel_we_i = 1'b0;
  endtask

  task automatic reg_wr(input int idx, input logic [31:0] d);
    wr_en_i = 1'b1; wr_idx_i = 4'(idx); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic expect_flush(input string tag, input logic [31:0] a);
    exp_fl.push_back(a); tag_fl.push_back(tag);
  endtask

  task automatic reg_rd(input string tag, input int idx, input logic [31:0] e);
    exp_rd.push_back(e); tag_rd.push_back(tag);
    rd_en_i = 1'b1; rd_idx_i = 4'(idx);
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 bank select", bsel_q_o, 32'h0);
    check("R1 rd_valid", 32'(rd_valid_o), 32'h0);
    check("R1 flush_valid", 32'(flush_valid_o), 32'h0);
    reg_rd("R1 register zero", 5, 32'h0);

    // R2 / R9 plain bank 0
    reg_wr(5, 32'hA5A5_0005);
    check("R9 no flush bank0", 32'(flush_valid_o), 32'h0);
    reg_wr(6, 32'h0000_1111);
    reg_rd("R2 bank0 reg5", 5, 32'hA5A5_0005);
    reg_rd("R9 bank0 cause untouched", 12, 32'h0);

    // bank 1: build an entry in set 2, entry 5
    set_bank(32'h1);
    reg_rd("R2 bank1 separate storage", 5, 32'h0);
    reg_wr(13, 32'h25);
    reg_wr(6, 32'h1234_7FFF);
    reg_rd("R4 cause copy", 12, 32'h1234_7FFF);
    reg_wr(5, 32'h0000_0008);
    check("R6 no flush for empty old entry", 32'(flush_valid_o), 32'h0);
    reg_rd("R5 committed hi from cause", 6, 32'h1234_7FFF);
    reg_rd("R5 committed lo", 5, 32'h0000_0008);

    // replace valid entry -> flush of old page
    reg_wr(6, 32'hABCD_E000);
    expect_flush("R6 flush of old valid page", 32'h1234_6000);
    reg_wr(5, 32'h0000_0000);
    check("R6 flush pulse high", 32'(flush_valid_o), 32'h1);
    @(negedge clk);
    check("R6 flush pulse one cycle", 32'(flush_valid_o), 32'h0);
    // replace invalid entry -> no flush
    reg_wr(5, 32'h0000_0008);
    check("R6 no flush for invalid old entry", 32'(flush_valid_o), 32'h0);
    reg_rd("R5 recommitted hi", 6, 32'hABCD_E000);

    // R3 set decoding
    reg_wr(13, 32'h05);
    reg_rd("R3 other set empty", 5, 32'h0);
    reg_wr(13, 32'h25);
    reg_rd("R3 set 2 entry 5", 5, 32'h0000_0008);

    // R7 mirror reload
    reg_wr(6, 32'h5555_0000);
    reg_rd("R7 hi reloaded from entry", 6, 32'hABCD_E000);
    reg_rd("R4 cause follows hi write", 12, 32'h5555_0000);

    // bank 2 maps to a different array bank
    set_bank(32'h2);
    reg_wr(13, 32'h25);
    reg_rd("R5 bank2 array separate", 5, 32'h0);
    reg_rd("R2 bank2 cause separate", 12, 32'h0);

    // R8 bank-select masking
    set_bank(32'hFFFF_FFF1);
    check("R8 full value held", bsel_q_o, 32'hFFFF_FFF1);
    reg_rd("R8 read in bank1", 5, 32'h0000_0008);
    check("R8 masked after read", bsel_q_o, 32'h1);

    // R10 read and write together
    wr_en_i = 1'b1; wr_idx_i = 4'd0; wr_data_i = 32'h77;
    rd_en_i = 1'b1; rd_idx_i = 4'd0;
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    check("R10 no read response", 32'(rd_valid_o), 32'h0);
    reg_rd("R10 write performed", 0, 32'h77);

    // R9 bank 3 has no side effects
    set_bank(32'h3);
    reg_wr(6, 32'h0000_0001);
    reg_rd("R9 bank3 cause untouched", 12, 32'h0);
    reg_wr(5, 32'h0000_0000);
    check("R9 no flush bank3", 32'(flush_valid_o), 32'h0);
    reg_rd("R9 bank3 lo stored plainly", 5, 32'h0);
    set_bank(32'h1);
    reg_rd("R9 bank1 entry untouched", 5, 32'h0000_0008);

    @(negedge clk);
    check("R6 all flushes seen", 32'(exp_fl.size()), 32'h0);
    check("R2 all reads answered", 32'(exp_rd.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule